// File: doc/BRIEF.md
# Pixel Pedestal and Width-Expansion Stage

This stage sits in the pixel path of one video layer. It sits after colour keying and ahead of any dithering. Each pixel carries three 8-bit colour components, named upper, middle and lower. The stage adds a signed offset to each component, and each component has its own offset. The sum is clamped to the unsigned pixel range. Each clamped value is then widened by one bit, using one of three fill rules for the new least significant bit: a zero, a copy of the most significant bit, or an undither rule that uses the previous pixel on the same line.

The input stream is qualified by a valid strobe and a start-of-line marker. A format flag says whether the chroma in the stream is full rate (4:4:4) or half rate (4:2:2). In 4:2:2 mode the middle and lower components carry chroma only on alternate pixels, and only those pixels receive the middle and lower offsets. All configuration arrives on plain ports. It is captured on a frame-start strobe, so every frame runs with one consistent setting. Results appear a fixed two cycles after the input, with valid and start-of-line delayed by the same amount.

Top module: `pix_ped_widen`

## Requirements
- R1: Each component's output value is the input plus its own pedestal: pedUp for upper, pedMid for middle and pedLow for lower. Each pedestal is read as two's complement (-128..127).
- R2: A sum below 0 is clamped to 0, and a sum above 255 is clamped to 255. The clamping happens before widening.
- R3: With cfgMode = 0 each 9-bit output is {v, 1'b0}, where v is the clamped 8-bit value.
- R4: With cfgMode = 1 each 9-bit output is {v, v[7]}.
- R5: With cfgMode = 2 or 3 each output is {v, v[0] ^ h}. Here h is v[0] of the previous valid pixel of the same component. h is 0 on a pixel that has inSol set. Cycles with inValid low leave h unchanged.
- R6: With cfgFmt422 = 1, a pixel that has inSol set is chroma pixel 0. After it, valid pixels alternate between not-chroma and chroma. Middle and lower get their pedestals only on chroma pixels and otherwise pass through unchanged. Upper always gets its pedestal. With cfgFmt422 = 0 every pixel gets all three pedestals.
- R7: outValid and outSol equal inValid and inSol of two rising edges earlier. Data is delivered with the same two-cycle latency.
- R8: The configuration ports are captured only on a rising edge where frameStart is high. The captured values apply to pixels presented in later cycles. Changing a configuration port without frameStart has no effect on the output.
- R9: Reset (rstN low) clears outValid and outSol. It also sets the captured configuration to zero pedestals, mode 0 and 4:4:4, so pixels that arrive before the first frameStart come out as {v, 1'b0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Capture configuration on this edge |
| inValid | input | 1 | Input pixel valid |
| inSol | input | 1 | Input pixel is first of its line |
| inUp | input | PIX_W | Upper component in |
| inMid | input | PIX_W | Middle component in |
| inLow | input | PIX_W | Lower component in |
| pedUp | input | PIX_W | Signed pedestal for upper |
| pedMid | input | PIX_W | Signed pedestal for middle |
| pedLow | input | PIX_W | Signed pedestal for lower |
| cfgMode | input | 2 | Widening rule select |
| cfgFmt422 | input | 1 | 1 = 4:2:2 input, 0 = 4:4:4 |
| outValid | output | 1 | Output pixel valid |
| outSol | output | 1 | Output pixel is first of its line |
| outUp | output | PIX_W+1 | Upper component out |
| outMid | output | PIX_W+1 | Middle component out |
| outLow | output | PIX_W+1 | Lower component out |

## Verification
The bench builds the block with the default PIX_W of 8. At that width, full-scale pedestals of +127 and -128 push sums past both clamp limits, and the bit that mode 1 copies is bit 7. The bench runs lines that switch between the widening modes and between 4:2:2 and 4:4:4, and it inserts idle cycles inside a line. This exercises the chroma phase and the undither history across line starts and gaps. It also pulses frameStart while a pixel is still in flight, and it changes the configuration ports with no frameStart.

// File: rtl/pix_ped_pkg.sv
package pix_ped_pkg;

  typedef enum logic [1:0] {
    WID_ZERO  = 2'd0,
    WID_MSB   = 2'd1,
    WID_UND_A = 2'd2,
    WID_UND_B = 2'd3
  } widenMode_t;

  typedef struct packed {
    logic valid;
    logic sol;
    logic chromaOn;
  } pxStrobe_t;

endpackage

// File: rtl/pix_ped_ctrl.sv
module pix_ped_ctrl
  import pix_ped_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int NCH   = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameStart,
  input  logic                       inValid,
  input  logic                       inSol,
  input  logic [NCH-1:0][PIX_W-1:0]  cfgPed,
  input  logic [1:0]                 cfgMode,
  input  logic                       cfgFmt422,
  output logic [NCH-1:0][PIX_W-1:0]  actPed,
  output widenMode_t                 actMode,
  output pxStrobe_t                  stb0,
  output pxStrobe_t                  stb1,
  output logic                       outValid,
  output logic                       outSol
);

  logic act422;
  logic phaseOdd;

  always_comb begin
    stb0.valid    = inValid;
    stb0.sol      = inSol;
    stb0.chromaOn = !act422 || inSol || !phaseOdd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actPed   <= '0;
      actMode  <= WID_ZERO;
      act422   <= 1'b0;
      phaseOdd <= 1'b0;
      stb1     <= '0;
      outValid <= 1'b0;
      outSol   <= 1'b0;
    end else begin
      if (frameStart) begin
        actPed  <= cfgPed;
        actMode <= widenMode_t'(cfgMode);
        act422  <= cfgFmt422;
      end
      if (inValid) begin
        phaseOdd <= inSol ? 1'b1 : !phaseOdd;
      end
      stb1     <= stb0;
      outValid <= stb1.valid;
      outSol   <= stb1.valid && stb1.sol;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> ($stable(actPed) && $stable(actMode) && $stable(act422))); // R8

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (actPed == $past(cfgPed))); // R8

  AST_CHROMA_ALT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && act422 && stb0.chromaOn && !frameStart) ##1 (inValid && !inSol)
      |-> !stb0.chromaOn); // R6

endmodule

// File: rtl/pix_ped_datapath.sv
module pix_ped_datapath
  import pix_ped_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int NCH   = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NCH-1:0][PIX_W-1:0]  inPix,
  input  logic [NCH-1:0][PIX_W-1:0]  actPed,
  input  widenMode_t                 actMode,
  input  pxStrobe_t                  stb0,
  input  pxStrobe_t                  stb1,
  output logic [NCH-1:0][PIX_W:0]    outPix
);

  localparam int SUM_W = PIX_W + 2;

  widenMode_t s1Mode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Mode <= WID_ZERO;
    end else if (stb0.valid) begin
      s1Mode <= actMode;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic                    applyPed;
    logic signed [SUM_W-1:0] sum;
    logic [PIX_W-1:0]        satVal;
    logic [PIX_W-1:0]        s1Val;
    logic                    hist;
    logic [PIX_W:0]          wideVal;
    logic [PIX_W:0]          outVal;

    if (c == 0) begin : g_luma
      assign applyPed = 1'b1;
    end else begin : g_chroma
      assign applyPed = stb0.chromaOn;
    end

    always_comb begin
      sum = $signed({2'b00, inPix[c]});
      if (applyPed) begin
        sum = sum + $signed({{2{actPed[c][PIX_W-1]}}, actPed[c]});
      end
      if (sum[SUM_W-1]) begin
        satVal = '0;
      end else if (sum[SUM_W-2]) begin
        satVal = '1;
      end else begin
        satVal = sum[PIX_W-1:0];
      end
    end

    always_comb begin
      case (s1Mode)
        WID_ZERO: wideVal = {s1Val, 1'b0};
        WID_MSB:  wideVal = {s1Val, s1Val[PIX_W-1]};
        default:  wideVal = {s1Val, (stb1.sol ? 1'b0 : hist) ^ s1Val[0]};
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        s1Val  <= '0;
        hist   <= 1'b0;
        outVal <= '0;
      end else begin
        if (stb0.valid) begin
          s1Val <= satVal;
        end
        if (stb1.valid) begin
          outVal <= wideVal;
          hist   <= s1Val[0];
        end
      end
    end

    assign outPix[c] = outVal;

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
      (stb1.valid && s1Mode == WID_ZERO) |=> (outVal[0] == 1'b0)); // R3

    AST_MSB_FILL: assert property (@(posedge clk) disable iff (!rstN)
      (stb1.valid && s1Mode == WID_MSB) |=> (outVal[0] == outVal[PIX_W])); // R4

    AST_LINE_UNDITHER: assert property (@(posedge clk) disable iff (!rstN)
      (stb1.valid && stb1.sol && s1Mode[1]) |=> (outVal[0] == outVal[1])); // R5

    AST_ZERO_PED: assert property (@(posedge clk) disable iff (!rstN)
      (stb0.valid && actPed[c] == '0) |=> (s1Val == $past(inPix[c]))); // R1
  end

endmodule

// File: rtl/pix_ped_widen.sv
module pix_ped_widen
  import pix_ped_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             inValid,
  input  logic             inSol,
  input  logic [PIX_W-1:0] inUp,
  input  logic [PIX_W-1:0] inMid,
  input  logic [PIX_W-1:0] inLow,
  input  logic [PIX_W-1:0] pedUp,
  input  logic [PIX_W-1:0] pedMid,
  input  logic [PIX_W-1:0] pedLow,
  input  logic [1:0]       cfgMode,
  input  logic             cfgFmt422,
  output logic             outValid,
  output logic             outSol,
  output logic [PIX_W:0]   outUp,
  output logic [PIX_W:0]   outMid,
  output logic [PIX_W:0]   outLow
);

  localparam int NCH = 3;

  logic [NCH-1:0][PIX_W-1:0] inPix;
  logic [NCH-1:0][PIX_W-1:0] cfgPed;
  logic [NCH-1:0][PIX_W-1:0] actPed;
  logic [NCH-1:0][PIX_W:0]   outPix;
  widenMode_t                actMode;
  pxStrobe_t                 stb0;
  pxStrobe_t                 stb1;

  assign inPix  = {inLow, inMid, inUp};
  assign cfgPed = {pedLow, pedMid, pedUp};

  pix_ped_ctrl #(.PIX_W(PIX_W), .NCH(NCH)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .inValid(inValid), .inSol(inSol),
    .cfgPed(cfgPed), .cfgMode(cfgMode), .cfgFmt422(cfgFmt422),
    .actPed(actPed), .actMode(actMode),
    .stb0(stb0), .stb1(stb1),
    .outValid(outValid), .outSol(outSol)
  );

  pix_ped_datapath #(.PIX_W(PIX_W), .NCH(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .inPix(inPix),
    .actPed(actPed), .actMode(actMode),
    .stb0(stb0), .stb1(stb1), .outPix(outPix)
  );

  assign outUp  = outPix[0];
  assign outMid = outPix[1];
  assign outLow = outPix[2];

  AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid); // R7

  AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid); // R7

endmodule

// File: tb/pix_ped_widen_tb.sv
module pix_ped_widen_tb;

  logic       clk = 1'b0;
  logic       rstN, frameStart, inValid, inSol, cfgFmt422;
  logic [7:0] inUp, inMid, inLow, pedUp, pedMid, pedLow;
  logic [1:0] cfgMode;
  logic       outValid, outSol;
  logic [8:0] outUp, outMid, outLow;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pix_ped_widen #(.PIX_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .inValid(inValid), .inSol(inSol),
    .inUp(inUp), .inMid(inMid), .inLow(inLow),
    .pedUp(pedUp), .pedMid(pedMid), .pedLow(pedLow),
    .cfgMode(cfgMode), .cfgFmt422(cfgFmt422),
    .outValid(outValid), .outSol(outSol),
    .outUp(outUp), .outMid(outMid), .outLow(outLow)
  );

  typedef struct packed {
    logic       frame;
    logic [1:0] mode;
    logic       fmt;
    logic [7:0] pu, pm, pl;
    logic       sol;
    logic [7:0] u, m, l;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b0, 8'd10,  8'hEC, 8'd0,   1'b1, 8'd100, 8'd100, 8'd5},
    '{1'b0, 2'd0, 1'b0, 8'd0,   8'd0,  8'd0,   1'b0, 8'd250, 8'd10,  8'd255},
    '{1'b1, 2'd1, 1'b0, 8'd0,   8'd0,  8'd127, 1'b1, 8'd200, 8'h80,  8'd200},
    '{1'b0, 2'd0, 1'b0, 8'd0,   8'd0,  8'd0,   1'b0, 8'h7F,  8'h81,  8'd3},
    '{1'b1, 2'd2, 1'b0, 8'd0,   8'd0,  8'd0,   1'b1, 8'd1,   8'd2,   8'd3},
    '{1'b0, 2'd0, 1'b0, 8'd0,   8'd0,  8'd0,   1'b0, 8'd1,   8'd3,   8'd2},
    '{1'b0, 2'd0, 1'b0, 8'd0,   8'd0,  8'd0,   1'b0, 8'd0,   8'd3,   8'd3},
    '{1'b0, 2'd0, 1'b0, 8'd0,   8'd0,  8'd0,   1'b1, 8'd5,   8'd5,   8'd4},
    '{1'b1, 2'd3, 1'b1, 8'd1,   8'h80, 8'd5,   1'b1, 8'd10,  8'd200, 8'd10},
    '{1'b0, 2'd0, 1'b0, 8'd0,   8'd0,  8'd0,   1'b0, 8'd10,  8'd200, 8'd10},
    '{1'b0, 2'd0, 1'b0, 8'd0,   8'd0,  8'd0,   1'b0, 8'd11,  8'd201, 8'd11},
    '{1'b0, 2'd0, 1'b0, 8'd0,   8'd0,  8'd0,   1'b1, 8'd12,  8'd202, 8'd12},
    '{1'b1, 2'd0, 1'b0, 8'd127, 8'h80, 8'h80,  1'b1, 8'd255, 8'd0,   8'd127},
    '{1'b0, 2'd0, 1'b0, 8'd0,   8'd0,  8'd0,   1'b0, 8'd129, 8'd128, 8'd128}
  };

  // independent reference model state
  logic [7:0] mPu, mPm, mPl;
  logic [1:0] mMode;
  logic       mFmt, mPhOdd;
  logic [2:0] mHist;
  logic       expV [2];
  logic       expS [2];
  logic [26:0] expD [2];
  string       expTag [2];

  function automatic logic [7:0] addSat(input logic [7:0] v, input logic [7:0] p);
    int s;
    s = int'(v) + int'($signed(p));
    if (s < 0) return 8'd0;
    if (s > 255) return 8'd255;
    return s[7:0];
  endfunction

  function automatic logic [8:0] widen(input logic [7:0] v, input logic [1:0] md,
                                       input logic h, input logic sol);
    if (md == 2'd0) return {v, 1'b0};
    if (md == 2'd1) return {v, v[7]};
    return {v, (sol ? 1'b0 : h) ^ v[0]};
  endfunction

  task automatic checkOut();
    checks++;
    if (outValid !== expV[1]) begin
      fails++;
      $display("FAIL R7 outValid actual %0b expected %0b", outValid, expV[1]);
    end
    if (expV[1]) begin
      checks++;
      if (outSol !== expS[1]) begin
        fails++;
        $display("FAIL R7 outSol actual %0b expected %0b", outSol, expS[1]);
      end
      checks++;
      if ({outLow, outMid, outUp} !== expD[1]) begin
        fails++;
        $display("FAIL %s data actual %h/%h/%h expected %h/%h/%h", expTag[1],
                 outUp, outMid, outLow, expD[1][8:0], expD[1][17:9], expD[1][26:18]);
      end
    end
  endtask

  task automatic tick(input logic v, input logic s, input logic [7:0] u,
                      input logic [7:0] m, input logic [7:0] l, input logic fr);
    logic [7:0] su, sm, sl;
    logic       cOn;
    @(negedge clk);
    checkOut();
    expV[1] = expV[0]; expS[1] = expS[0]; expD[1] = expD[0]; expTag[1] = expTag[0];
    expV[0] = v; expS[0] = s;
    if (v) begin
      cOn = !mFmt || s || !mPhOdd;          // R6 chroma phase
      su  = addSat(u, mPu);                 // R1 R2
      sm  = cOn ? addSat(m, mPm) : m;
      sl  = cOn ? addSat(l, mPl) : l;
      expD[0] = {widen(sl, mMode, mHist[2], s), widen(sm, mMode, mHist[1], s),
                 widen(su, mMode, mHist[0], s)};
      expTag[0] = (mMode == 2'd0) ? "R1 R2 R3" : (mMode == 2'd1) ? "R1 R2 R4" : "R1 R5";
      if (mFmt) expTag[0] = {expTag[0], " R6"};
      mHist  = {sl[0], sm[0], su[0]};
      mPhOdd = s ? 1'b1 : !mPhOdd;
    end
    if (fr) begin                           // R8 capture
      mPu = pedUp; mPm = pedMid; mPl = pedLow; mMode = cfgMode; mFmt = cfgFmt422;
    end
    inValid = v; inSol = s; inUp = u; inMid = m; inLow = l; frameStart = fr;
  endtask

  task automatic setCfg(input logic [1:0] md, input logic f, input logic [7:0] pu,
                        input logic [7:0] pm, input logic [7:0] pl);
    cfgMode = md; cfgFmt422 = f; pedUp = pu; pedMid = pm; pedLow = pl;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; frameStart = 1'b0; inValid = 1'b0; inSol = 1'b0;
    inUp = '0; inMid = '0; inLow = '0;
    setCfg(2'd2, 1'b1, 8'd9, 8'd9, 8'd9);
    mPu = '0; mPm = '0; mPl = '0; mMode = '0; mFmt = 1'b0; mPhOdd = 1'b0; mHist = '0;
    for (int i = 0; i < 2; i++) begin expV[i] = 1'b0; expS[i] = 1'b0; expD[i] = '0; expTag[i] = ""; end
    repeat (3) @(negedge clk);
    // R9 reset state
    checks++;
    if (outValid !== 1'b0 || outSol !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset outValid/outSol actual %0b%0b expected 00", outValid, outSol);
    end
    rstN = 1'b1;
    // R9: no frameStart yet, so zero pedestals and mode 0 despite ports
    tick(1'b1, 1'b1, 8'd77, 8'd200, 8'd3, 1'b0);
    tick(1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 1'b0);
    tick(1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 1'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].frame) begin
        setCfg(VECS[i].mode, VECS[i].fmt, VECS[i].pu, VECS[i].pm, VECS[i].pl);
        tick(1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 1'b1);
      end
      tick(1'b1, VECS[i].sol, VECS[i].u, VECS[i].m, VECS[i].l, 1'b0);
    end

    // R8: config ports change without frameStart: no effect
    setCfg(2'd1, 1'b1, 8'd50, 8'd50, 8'd50);
    tick(1'b1, 1'b1, 8'd20, 8'd20, 8'd20, 1'b0);
    tick(1'b1, 1'b0, 8'd21, 8'd21, 8'd21, 1'b0);

    // R5 R6: undither in 4:2:2 with gaps inside a line
    setCfg(2'd2, 1'b1, 8'd3, 8'd1, 8'hFF);
    tick(1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 1'b1);
    tick(1'b1, 1'b1, 8'd6, 8'd7, 8'd8, 1'b0);
    tick(1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 1'b0);
    tick(1'b1, 1'b0, 8'd7, 8'd8, 8'd9, 1'b0);
    tick(1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 1'b0);
    tick(1'b1, 1'b0, 8'd9, 8'd9, 8'd9, 1'b0);
    tick(1'b1, 1'b0, 8'd8, 8'd8, 8'd8, 1'b0);
    tick(1'b1, 1'b1, 8'd1, 8'd1, 8'd1, 1'b0);
    tick(1'b1, 1'b0, 8'd2, 8'd3, 8'd4, 1'b0);

    // R8 R4: frameStart in the same cycle as a pixel; that pixel keeps old settings
    setCfg(2'd1, 1'b0, 8'hF6, 8'd0, 8'd20);
    tick(1'b1, 1'b0, 8'd200, 8'd201, 8'd202, 1'b1);
    tick(1'b1, 1'b1, 8'd200, 8'd5, 8'd250, 1'b0);
    tick(1'b1, 1'b0, 8'd5, 8'd128, 8'd0, 1'b0);

    // flush pipeline
    repeat (3) tick(1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule